// File: doc/BRIEF.md
# Double-Buffered Compare Timer

This block is a free-running up counter with two compare registers, each of which raises its own one-cycle match strobe when the counter reaches it. Compare register 1 sets the period: the counter returns to zero on the clock after it equals register 1. Compare register 0 marks a point inside that period, so a downstream output stage can build a PWM waveform from the two strobes.

Software programs the block over a byte-wide write port. A low byte is held in a staging latch, and it takes effect together with the high byte when the high byte is written, so a half-updated value is never compared. Register 0 can be placed behind a shadow buffer. When the buffer is on, new values wait there and move into register 0 only at the end of a period, when the counter hits register 1. This lets software change the duty point mid-period without creating a glitch. Software must load both registers before starting the counter.

Top module: `dbcmp_timer`

## Requirements
- R1: Out of reset the counter is 0, both match strobes are low, and the control register reads back 0, meaning stopped with the buffer off.
- R2: While the run bit (control bit 0, at write address 4) is 0, the counter is held at 0 and neither match strobe is raised.
- R3: While running, the counter increases by one on each clock. On the clock after it equals compare register 1, it becomes 0 instead.
- R4: match1 is high in exactly those running cycles where the counter equals compare register 1. match0 is high in exactly those running cycles where the counter equals compare register 0.
- R5: A write to a low-byte address (0 for register 0, 2 for register 1) changes no compare value. A write to the matching high-byte address (1 or 3) loads the 16-bit value formed from the written high byte and the last staged low byte.
- R6: With the buffer-enable bit (control bit 1) at 0, a completed write to register 0 loads both register 0 and its shadow buffer, and register 0 takes the new value from the next clock.
- R7: With the buffer-enable bit at 1, a completed write to register 0 loads only the shadow buffer, and register 0 keeps its old value.
- R8: With the buffer-enable bit at 1 and the counter running, register 0 takes the shadow value on the clock after the counter equals register 1.
- R9: Reads return 0 at the compare-register addresses 0 to 3. A read at address 4 returns the run bit in bit 0 and the buffer-enable bit in bit 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | DATA_W | Write data byte |
| rd_addr | input | 3 | Read address |
| rd_data | output | DATA_W | Read data (control only) |
| count | output | CNT_W | Counter value |
| match0 | output | 1 | Counter equals compare register 0 |
| match1 | output | 1 | Counter equals compare register 1 |

## Verification
The bench uses the default widths: an 8-bit bus and a 16-bit counter, so two byte lanes per register. Most random compare values keep a zero high byte, which gives periods of a few dozen clocks. That allows many wraps and buffer transfers within the run. An occasional non-zero high byte exercises the upper lane, the high-byte commit and a long period. The same stimulus also brings in writes on the match cycle and buffer-enable changes in the middle of a period.

// File: rtl/dbcmp_pkg.sv
package dbcmp_pkg;
   localparam int ADDR_W = 3;

   typedef enum logic [ADDR_W-1:0] {
      A_CMP0_LO = 3'd0,
      A_CMP0_HI = 3'd1,
      A_CMP1_LO = 3'd2,
      A_CMP1_HI = 3'd3,
      A_CTRL    = 3'd4
   } addr_e;

   localparam int CTRL_RUN_BIT = 0;
   localparam int CTRL_BUF_BIT = 1;
endpackage

// File: rtl/dbcmp_regs.sv
module dbcmp_regs
   import dbcmp_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              xfer,
   output logic [CNT_W-1:0]  cmp0,
   output logic [CNT_W-1:0]  cmp1,
   output logic [CNT_W-1:0]  shadow,
   output logic              run,
   output logic              buf_en
);
   localparam int NREG = 2;

   logic [CNT_W-1:0] val    [NREG];
   logic             commit [NREG];

   // one staging latch per compare register; low lane at 2*i, high at 2*i+1
   for (genvar i = 0; i < NREG; i++) begin : g_stage
      logic [DATA_W-1:0] stage_q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            stage_q <= '0;
         else if (wr_en && wr_addr == ADDR_W'(2*i))
            stage_q <= wr_data;
      end
      assign commit[i] = wr_en && (wr_addr == ADDR_W'(2*i+1));
      assign val[i]    = {wr_data, stage_q};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmp0   <= '0;
         cmp1   <= '0;
         shadow <= '0;
         run    <= 1'b0;
         buf_en <= 1'b0;
      end else begin
         if (commit[1])
            cmp1 <= val[1];
         if (commit[0])
            shadow <= val[0];
         if (xfer)
            cmp0 <= shadow;
         else if (commit[0] && !buf_en)
            cmp0 <= val[0];
         if (wr_en && wr_addr == A_CTRL) begin
            run    <= wr_data[CTRL_RUN_BIT];
            buf_en <= wr_data[CTRL_BUF_BIT];
         end
      end
   end
endmodule

// File: rtl/dbcmp_counter.sv
module dbcmp_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             wrap,
   output logic [CNT_W-1:0] count
);
   always_ff @(posedge clk) begin
      if (!rst_n || !run)
         count <= '0;
      else if (wrap)
         count <= '0;
      else
         count <= count + CNT_W'(1);
   end
endmodule

// File: rtl/dbcmp_cmp.sv
module dbcmp_cmp #(
   parameter int CNT_W = 16
) (
   input  logic             en,
   input  logic [CNT_W-1:0] count,
   input  logic [CNT_W-1:0] ref_val,
   output logic             hit
);
   assign hit = en && (count == ref_val);
endmodule

// File: rtl/dbcmp_timer.sv
module dbcmp_timer
   import dbcmp_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic [CNT_W-1:0]  count,
   output logic              match0,
   output logic              match1
);
   localparam int NCMP = 2;

   if (CNT_W != 2 * DATA_W) begin : g_width_bad
      $error("dbcmp_timer: CNT_W must be twice DATA_W");
   end
   if (DATA_W < 2) begin : g_data_bad
      $error("dbcmp_timer: DATA_W must hold the control bits");
   end

   logic [CNT_W-1:0] cmp0, cmp1, shadow;
   logic             run, buf_en;
   logic [CNT_W-1:0] ref_val [NCMP];
   logic             hit     [NCMP];

   dbcmp_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_en),
      .wr_addr(wr_addr),
      .wr_data(wr_data),
      .xfer   (buf_en && hit[1]),
      .cmp0   (cmp0),
      .cmp1   (cmp1),
      .shadow (shadow),
      .run    (run),
      .buf_en (buf_en)
   );

   dbcmp_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (run),
      .wrap (hit[1]),
      .count(count)
   );

   assign ref_val[0] = cmp0;
   assign ref_val[1] = cmp1;

   for (genvar i = 0; i < NCMP; i++) begin : g_cmp
      dbcmp_cmp #(.CNT_W(CNT_W)) u_cmp (
         .en     (run),
         .count  (count),
         .ref_val(ref_val[i]),
         .hit    (hit[i])
      );
   end

   assign match0 = hit[0];
   assign match1 = hit[1];

   always_comb begin
      rd_data = '0;
      if (rd_addr == A_CTRL) begin
         rd_data[CTRL_RUN_BIT] = run;
         rd_data[CTRL_BUF_BIT] = buf_en;
      end
   end
endmodule

// File: rtl/dbcmp_timer_chk.sv
module dbcmp_timer_chk
   import dbcmp_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [CNT_W-1:0]  count,
   input logic              match0,
   input logic              match1,
   input logic              run,
   input logic              buf_en,
   input logic [CNT_W-1:0]  cmp0,
   input logic [CNT_W-1:0]  cmp1,
   input logic [CNT_W-1:0]  shadow
);
   // R2
   hold_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> count == '0);

   // R2
   idle_nomatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> !match0 && !match1);

   // R3
   wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && count == cmp1) |=> count == '0);

   // R3
   step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && count != cmp1) |=> count == $past(count) + CNT_W'(1));

   // R5
   lo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == A_CMP0_LO && !(buf_en && match1)) |=> $stable(cmp0));

   // R6
   direct_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!buf_en && wr_en && wr_addr == A_CMP0_HI) |=> cmp0 == shadow);

   // R7
   shadow_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (buf_en && !match1 && wr_en && wr_addr == A_CMP0_HI) |=> $stable(cmp0));

   // R8
   xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (buf_en && match1) |=> cmp0 == $past(shadow));
endmodule

bind dbcmp_timer dbcmp_timer_chk #(.CNT_W(CNT_W)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .wr_en  (wr_en),
   .wr_addr(wr_addr),
   .count  (count),
   .match0 (match0),
   .match1 (match1),
   .run    (run),
   .buf_en (buf_en),
   .cmp0   (cmp0),
   .cmp1   (cmp1),
   .shadow (shadow)
);

// File: tb/dbcmp_timer_test.sv
module dbcmp_timer_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [7:0]  wr_data = '0;
   logic [2:0]  rd_addr = '0;
   logic [7:0]  rd_data;
   logic [15:0] count;
   logic        match0, match1;

   int n_chk = 0;
   int n_err = 0;
   bit done = 0;

   // reference state, kept from the requirements
   logic [15:0] m_cnt = '0, m_c0 = '0, m_c1 = '0, m_sh = '0;
   logic [7:0]  m_st0 = '0, m_st1 = '0;
   logic        m_run = 0, m_be = 0;

   dbcmp_timer uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .count(count), .match0(match0), .match1(match1)
   );

   always #5 clk = ~clk;

   task automatic chk(input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   function automatic logic exp_m0();
      return m_run && (m_cnt == m_c0);
   endfunction

   function automatic logic exp_m1();
      return m_run && (m_cnt == m_c1);
   endfunction

   task automatic check_outs(input string tag);
      chk(tag, "count", 32'(count), 32'(m_cnt));
      chk(tag, "match0", 32'(match0), 32'(exp_m0()));
      chk(tag, "match1", 32'(match1), 32'(exp_m1()));
   endtask

   task automatic step(input logic we, input logic [2:0] a,
                       input logic [7:0] d, input string tag);
      logic [15:0] n_cnt, n_c0, n_c1, n_sh;
      logic [7:0]  n_st0, n_st1;
      logic        n_run, n_be;
      wr_en = we; wr_addr = a; wr_data = d;
      n_cnt = !m_run ? 16'd0 : (m_cnt == m_c1 ? 16'd0 : m_cnt + 16'd1);
      n_c0 = m_c0; n_c1 = m_c1; n_sh = m_sh;
      n_st0 = m_st0; n_st1 = m_st1; n_run = m_run; n_be = m_be;
      if (m_be && exp_m1()) n_c0 = m_sh;
      if (we) begin
         case (a)
            3'd0: n_st0 = d;
            3'd1: begin n_sh = {d, m_st0}; if (!m_be) n_c0 = {d, m_st0}; end
            3'd2: n_st1 = d;
            3'd3: n_c1 = {d, m_st1};
            3'd4: begin n_run = d[0]; n_be = d[1]; end
            default: ;
         endcase
      end
      @(posedge clk);
      #1;
      wr_en = 1'b0;
      m_cnt = n_cnt; m_c0 = n_c0; m_c1 = n_c1; m_sh = n_sh;
      m_st0 = n_st0; m_st1 = n_st1; m_run = n_run; m_be = n_be;
      check_outs(tag);
   endtask

   task automatic idle(input int n, input string tag);
      for (int i = 0; i < n; i++) step(1'b0, 3'd0, 8'd0, tag);
   endtask

   task automatic wr16(input logic [2:0] lo, input logic [15:0] v, input string tag);
      step(1'b1, lo, v[7:0], tag);
      step(1'b1, lo + 3'd1, v[15:8], tag);
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   endtask

   initial begin
      #1_500_000;
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog expired");
         finish_run();
      end
   end

   initial begin
      int seen0;
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk);
      #1;
      rst_n = 1'b1;
      rd_addr = 3'd4;
      #1;
      // R1 reset state
      chk("R1", "count", 32'(count), 0);
      chk("R1", "match0", 32'(match0), 0);
      chk("R1", "match1", 32'(match1), 0);
      chk("R1", "ctrl", 32'(rd_data), 0);

      // R2 stopped counter stays at zero even with compares loaded
      wr16(3'd0, 16'd5, "R2");
      wr16(3'd2, 16'd9, "R2");
      wr16(3'd2, 16'd0, "R2");
      idle(4, "R2");
      wr16(3'd2, 16'd9, "R2");
      idle(4, "R2");

      // R9 compare addresses read as zero
      for (int a = 0; a < 4; a++) begin
         rd_addr = 3'(a);
         #1;
         chk("R9", "rd cmp", 32'(rd_data), 0);
      end

      // R3 R4 run through several periods
      step(1'b1, 3'd4, 8'h01, "R3");
      rd_addr = 3'd4;
      #1;
      chk("R9", "rd ctrl run", 32'(rd_data), 32'h1);
      idle(25, "R3 R4");

      // R5 staged low byte has no effect until the high byte
      step(1'b1, 3'd0, 8'd7, "R5");
      seen0 = 0;
      for (int i = 0; i < 12; i++) begin
         step(1'b0, 3'd0, 8'd0, "R5");
         if (count == 16'd7 && match0) seen0++;
      end
      chk("R5", "no match at staged value", 32'(seen0), 0);
      step(1'b1, 3'd1, 8'd0, "R5");
      idle(12, "R5 R6");

      // R7 R8 buffered update applied at the period end
      step(1'b1, 3'd4, 8'h03, "R7");
      #1;
      chk("R9", "rd ctrl both", 32'(rd_data), 32'h3);
      wr16(3'd0, 16'd2, "R7");
      idle(24, "R7 R8");

      // R6 buffer off again: writes go straight to register 0
      step(1'b1, 3'd4, 8'h01, "R6");
      wr16(3'd0, 16'd4, "R6");
      idle(12, "R6");

      // R8 write on the match cycle with buffer on
      step(1'b1, 3'd4, 8'h03, "R8");
      while (!(m_cnt == m_c1 - 16'd1)) step(1'b0, 3'd0, 8'd0, "R8");
      step(1'b1, 3'd0, 8'd3, "R8");
      step(1'b1, 3'd1, 8'd0, "R8");
      idle(24, "R8");

      // constrained random mix
      for (int i = 0; i < 6000; i++) begin
         int r;
         logic [7:0] d;
         r = $urandom_range(0, 99);
         if (r < 80) begin
            step(1'b0, 3'd0, 8'd0, "R3 R4 R8");
         end else begin
            logic [2:0] a;
            a = 3'($urandom_range(0, 4));
            if (a == 3'd4)
               d = ($urandom_range(0, 9) < 8 ? 8'h01 : 8'h00) | ($urandom_range(0, 1) ? 8'h02 : 8'h00);
            else if (a[0])
               d = ($urandom_range(0, 19) == 0) ? 8'($urandom_range(1, 2)) : 8'd0;
            else
               d = 8'($urandom_range(0, 40));
            step(1'b1, a, d, "R5 R6 R7");
         end
      end

      // R2 stop again
      step(1'b1, 3'd4, 8'h00, "R2");
      idle(5, "R2");

      done = 1;
      finish_run();
   end
endmodule